// File: doc/BRIEF.md
# Thermal Trip Alarm Controller

This block sets a single thermal alarm line after every temperature conversion. It receives each 9-bit signed temperature result with a valid strobe. It compares the result against a programmable trip threshold and a lower release threshold, and it filters the result through a consecutive-sample agreement counter. It then updates the alarm in one of two modes. In thermostat mode the alarm is a level with hysteresis. In latched-interrupt mode an event is held until any host register read clears it.

The alarm is presented as a logical pin level plus an open-drain pull-low enable, and its active level is selectable. The register bank that feeds the thresholds and configuration bits lives outside this block. The package publishes the power-up values that this bank must load: trip 0x0A0 (80 °C), release 0x096 (75 °C), queue code 00, thermostat mode, active-low and running. When the block is shut down it ignores conversions. On entry to shutdown it drops a pending interrupt, but it keeps a thermostat alarm where it is.

Top module: `thermal_trip_alarm`

## Requirements
- R1: After reset, with the package default configuration applied (thermostat mode, active-low polarity, queue code 00, running), the alarm is inactive: `alarmLevel` = 1 and `alarmPullLow` = 0.
- R2: Temperatures and thresholds are 9-bit two's complement values, with 1 LSB = 0.5 °C. A sample is "hot" when it is signed-greater than `tripPoint`, and "cold" when it is signed-less than `hystPoint`. Hot takes priority if both hold. Any other sample is neutral.
- R3: `cfgQueueDepth` selects how many consecutive samples of the same class are needed before that class takes effect: 00→1, 01→2, 10→4, 11→6. A neutral sample, or a sample of the other class, restarts the run.
- R4: In thermostat mode (`cfgIntMode` = 0) a qualified hot result makes the alarm active, and a qualified cold result makes it inactive. Neutral samples leave it unchanged. The output reflects a sample at the clock edge that captures `sampleValid`.
- R5: In interrupt mode (`cfgIntMode` = 1), a qualified hot result sets the alarm. The alarm stays set through any later samples until a `regReadPulse` clears it. If an event and a read fall in the same cycle, the event wins.
- R6: In interrupt mode, after a hot event only a qualified cold result can raise the next event. After a cold event only a qualified hot result can raise the next one. Each crossing fires exactly once.
- R7: While `cfgShutdown` = 1, samples have no effect on the alarm or on the run counter. A thermostat alarm keeps its state.
- R8: Raising `cfgShutdown` while in interrupt mode clears the alarm on the next clock edge.
- R9: `cfgActiveHigh` = 1 makes `alarmLevel` equal to the active state, and 0 makes it the inverse. `alarmPullLow` is always the inverse of `alarmLevel`.
- R10: Any change of `cfgIntMode` clears the alarm, the interrupt arming (back to awaiting a hot crossing) and the run counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Strobe marking a new conversion result |
| sampleTemp | input | 9 | Conversion result, two's complement half-degrees |
| tripPoint | input | 9 | Upper (trip) threshold |
| hystPoint | input | 9 | Lower (release) threshold |
| cfgShutdown | input | 1 | 1 = conversions ignored |
| cfgIntMode | input | 1 | 0 = thermostat, 1 = latched interrupt |
| cfgActiveHigh | input | 1 | 0 = active low, 1 = active high |
| cfgQueueDepth | input | 2 | Agreement depth code |
| regReadPulse | input | 1 | One-cycle pulse for any host register read |
| alarmLevel | output | 1 | Logical level of the alarm pin |
| alarmPullLow | output | 1 | Open-drain enable: pull the pin low |

## Verification
The signed comparison is swept over every 9-bit sample value against thresholds that straddle zero and against the default ones. A design that compared unsigned, or that used greater-or-equal, would trip on negative values or exactly at the threshold. For each depth code, mixed hot, cold and neutral sequences are checked to catch a run counter that fails to restart on a neutral sample, or that misreads code 11 as 8. In interrupt mode the bench goes after re-firing while the temperature stays hot, a read and an event landing in the same cycle, and shutdown entry in both modes. A design that armed wrongly would raise a second interrupt, and one that gave the read priority would lose an event.

// File: rtl/thermal_alarm_pkg.sv
package thermal_alarm_pkg;

  localparam int TEMP_W  = 9;
  localparam int MAX_RUN = 6;
  localparam int RUN_W   = $clog2(MAX_RUN + 1);

  // Values the owning register bank loads at power-up
  localparam logic [TEMP_W-1:0] DEF_TRIP  = 9'h0A0;  // 80.0 C
  localparam logic [TEMP_W-1:0] DEF_HYST  = 9'h096;  // 75.0 C
  localparam logic [1:0]        DEF_QUEUE = 2'b00;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_HOT  = 2'd1,
    CLS_COLD = 2'd2
  } sampleClass_t;

  typedef struct packed {
    logic evalEn;     // sample counts this cycle
    logic flushAll;   // mode changed: clear everything
    logic dropLatch;  // clear interrupt latch
    logic readAck;    // host register read seen
    logic intMode;    // current mode
  } alarmStrobe_t;

  function automatic logic [RUN_W-1:0] queueNeed(input logic [1:0] code);
    logic [RUN_W-1:0] need;
    case (code)
      2'b00:   need = RUN_W'(1);
      2'b01:   need = RUN_W'(2);
      2'b10:   need = RUN_W'(4);
      default: need = RUN_W'(MAX_RUN);
    endcase
    return need;
  endfunction

endpackage

// File: rtl/thermal_alarm_ctrl.sv
module thermal_alarm_ctrl
  import thermal_alarm_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         sampleValid,
  input  logic         cfgShutdown,
  input  logic         cfgIntMode,
  input  logic         regReadPulse,
  output alarmStrobe_t strobe
);

  logic prevMode;
  logic prevShut;
  logic modeFlip;
  logic shutEntry;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevMode <= 1'b0;
      prevShut <= 1'b0;
    end else begin
      prevMode <= cfgIntMode;
      prevShut <= cfgShutdown;
    end
  end

  always_comb begin
    modeFlip         = cfgIntMode != prevMode;
    shutEntry        = cfgShutdown && !prevShut;
    strobe.evalEn    = sampleValid && !cfgShutdown && !modeFlip;
    strobe.flushAll  = modeFlip;
    strobe.dropLatch = modeFlip || (shutEntry && cfgIntMode);
    strobe.readAck   = regReadPulse;
    strobe.intMode   = cfgIntMode;
  end

  AST_SHUT_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgShutdown) && cfgIntMode |-> strobe.dropLatch)
    else $error("shutdown entry did not drop latch");  // R8

  AST_SHUT_NO_EVAL: assert property (@(posedge clk) disable iff (!rstN)
    cfgShutdown |-> !strobe.evalEn)
    else $error("sample evaluated in shutdown");  // R7

endmodule

// File: rtl/thermal_alarm_filter.sv
module thermal_alarm_filter
  import thermal_alarm_pkg::*;
#(
  parameter int SAMPLE_W = TEMP_W,
  parameter int CNT_W    = RUN_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                evalEn,
  input  logic                flushRun,
  input  logic [SAMPLE_W-1:0] sampleTemp,
  input  logic [SAMPLE_W-1:0] tripPoint,
  input  logic [SAMPLE_W-1:0] hystPoint,
  input  logic [1:0]          queueCode,
  output logic                qualHot,
  output logic                qualCold
);

  localparam logic [CNT_W-1:0] RUN_CAP = CNT_W'(MAX_RUN);

  sampleClass_t     lastClass;
  sampleClass_t     curClass;
  logic [CNT_W-1:0] runCount;
  logic [CNT_W-1:0] nextRun;
  logic [CNT_W-1:0] need;
  logic             isHot;
  logic             isCold;

  always_comb begin
    isHot  = $signed(sampleTemp) > $signed(tripPoint);
    isCold = $signed(sampleTemp) < $signed(hystPoint);
    if (isHot)       curClass = CLS_HOT;
    else if (isCold) curClass = CLS_COLD;
    else             curClass = CLS_NONE;

    if (curClass == CLS_NONE)       nextRun = '0;
    else if (curClass == lastClass) nextRun = (runCount >= RUN_CAP) ? RUN_CAP : runCount + CNT_W'(1);
    else                            nextRun = CNT_W'(1);

    need     = queueNeed(queueCode);
    qualHot  = evalEn && (curClass == CLS_HOT)  && (nextRun >= need);
    qualCold = evalEn && (curClass == CLS_COLD) && (nextRun >= need);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCount  <= '0;
      lastClass <= CLS_NONE;
    end else if (flushRun) begin
      runCount  <= '0;
      lastClass <= CLS_NONE;
    end else if (evalEn) begin
      runCount  <= nextRun;
      lastClass <= curClass;
    end
  end

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    runCount <= RUN_CAP)
    else $error("run counter beyond cap");  // R3

  AST_DEEP_QUEUE: assert property (@(posedge clk) disable iff (!rstN)
    qualHot && queueCode == 2'b11 |-> runCount >= RUN_CAP - CNT_W'(1))
    else $error("hot qualified before six samples");  // R3

  AST_IDLE_NO_QUAL: assert property (@(posedge clk) disable iff (!rstN)
    !evalEn |=> $stable(runCount) || runCount == '0)
    else $error("run counter moved without a sample");  // R7

endmodule

// File: rtl/thermal_alarm_state.sv
module thermal_alarm_state
  import thermal_alarm_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  alarmStrobe_t strobe,
  input  logic         qualHot,
  input  logic         qualCold,
  input  logic         cfgActiveHigh,
  output logic         alarmLevel,
  output logic         alarmPullLow
);

  logic compState;
  logic intLatch;
  logic armedLow;
  logic intEvent;
  logic alarmActive;

  always_comb begin
    intEvent    = strobe.intMode && ((!armedLow && qualHot) || (armedLow && qualCold));
    alarmActive = strobe.intMode ? intLatch : compState;
    alarmLevel  = cfgActiveHigh ? alarmActive : !alarmActive;
    alarmPullLow = !alarmLevel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      compState <= 1'b0;
    end else if (strobe.flushAll) begin
      compState <= 1'b0;
    end else if (!strobe.intMode && qualHot) begin
      compState <= 1'b1;
    end else if (!strobe.intMode && qualCold) begin
      compState <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intLatch <= 1'b0;
      armedLow <= 1'b0;
    end else begin
      if (strobe.dropLatch)    intLatch <= 1'b0;
      else if (intEvent)       intLatch <= 1'b1;
      else if (strobe.readAck) intLatch <= 1'b0;

      if (strobe.flushAll)     armedLow <= 1'b0;
      else if (intEvent)       armedLow <= !armedLow;
    end
  end

  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.intMode && strobe.readAck && !qualHot && !qualCold |=> !intLatch)
    else $error("read did not clear interrupt");  // R5

  AST_NO_REFIRE: assert property (@(posedge clk) disable iff (!rstN)
    armedLow && !qualCold && !strobe.flushAll |=> armedLow)
    else $error("arming changed without cold crossing");  // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.evalEn && !strobe.flushAll |=> $stable(compState))
    else $error("thermostat state moved without sample");  // R7

  AST_DROP_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dropLatch |=> !intLatch)
    else $error("latch survived drop");  // R8

  AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flushAll |=> !compState && !intLatch && !armedLow)
    else $error("mode change left state");  // R10

endmodule

// File: rtl/thermal_trip_alarm.sv
module thermal_trip_alarm
  import thermal_alarm_pkg::*;
#(
  parameter int SAMPLE_W = TEMP_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleTemp,
  input  logic [SAMPLE_W-1:0] tripPoint,
  input  logic [SAMPLE_W-1:0] hystPoint,
  input  logic                cfgShutdown,
  input  logic                cfgIntMode,
  input  logic                cfgActiveHigh,
  input  logic [1:0]          cfgQueueDepth,
  input  logic                regReadPulse,
  output logic                alarmLevel,
  output logic                alarmPullLow
);

  alarmStrobe_t strobe;
  logic         qualHot;
  logic         qualCold;

  thermal_alarm_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .sampleValid  (sampleValid),
    .cfgShutdown  (cfgShutdown),
    .cfgIntMode   (cfgIntMode),
    .regReadPulse (regReadPulse),
    .strobe       (strobe)
  );

  thermal_alarm_filter #(.SAMPLE_W(SAMPLE_W), .CNT_W(RUN_W)) u_filter (
    .clk        (clk),
    .rstN       (rstN),
    .evalEn     (strobe.evalEn),
    .flushRun   (strobe.flushAll),
    .sampleTemp (sampleTemp),
    .tripPoint  (tripPoint),
    .hystPoint  (hystPoint),
    .queueCode  (cfgQueueDepth),
    .qualHot    (qualHot),
    .qualCold   (qualCold)
  );

  thermal_alarm_state u_state (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .qualHot       (qualHot),
    .qualCold      (qualCold),
    .cfgActiveHigh (cfgActiveHigh),
    .alarmLevel    (alarmLevel),
    .alarmPullLow  (alarmPullLow)
  );

  AST_PIN_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    alarmPullLow != alarmLevel)
    else $error("pull-low and level disagree");  // R9

endmodule

// File: tb/thermal_trip_alarm_test.sv
module thermal_trip_alarm_test;
  import thermal_alarm_pkg::*;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleValid = 1'b0;
  logic [8:0] sampleTemp = '0;
  logic [8:0] tripPoint = DEF_TRIP;
  logic [8:0] hystPoint = DEF_HYST;
  logic       cfgShutdown = 1'b0;
  logic       cfgIntMode = 1'b0;
  logic       cfgActiveHigh = 1'b0;
  logic [1:0] cfgQueueDepth = DEF_QUEUE;
  logic       regReadPulse = 1'b0;
  logic       alarmLevel;
  logic       alarmPullLow;

  int checks = 0;
  int fails = 0;

  // reference state, built from the requirements
  int mTrip = 160, mHyst = 150, mDepth = 0, mRun = 0, mLast = 0;
  bit mComp = 0, mLatch = 0, mArm = 0, mInt = 0, mShut = 0, mHigh = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;  // 50 MHz

  thermal_trip_alarm uut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleTemp(sampleTemp),
    .tripPoint(tripPoint), .hystPoint(hystPoint), .cfgShutdown(cfgShutdown),
    .cfgIntMode(cfgIntMode), .cfgActiveHigh(cfgActiveHigh),
    .cfgQueueDepth(cfgQueueDepth), .regReadPulse(regReadPulse),
    .alarmLevel(alarmLevel), .alarmPullLow(alarmPullLow)
  );

  function automatic int needOf(int code);
    return (code == 0) ? 1 : (code == 1) ? 2 : (code == 2) ? 4 : 6;
  endfunction

  task automatic modelSample(int t, bit rd);
    int cls;
    bit qh, qc, ev;
    ev = 0;
    if (!mShut) begin
      cls = (t > mTrip) ? 1 : (t < mHyst) ? 2 : 0;
      if (cls == 0) mRun = 0;
      else if (cls == mLast) mRun = (mRun >= 6) ? 6 : mRun + 1;
      else mRun = 1;
      mLast = cls;
      qh = (cls == 1) && (mRun >= needOf(mDepth));
      qc = (cls == 2) && (mRun >= needOf(mDepth));
      if (!mInt) begin
        if (qh) mComp = 1;
        else if (qc) mComp = 0;
      end else begin
        ev = mArm ? qc : qh;
        if (ev) begin mLatch = 1; mArm = !mArm; end
      end
    end
    if (mInt && rd && !ev) mLatch = 0;
  endtask

  task automatic check(string tag);
    bit act;
    bit expLvl;
    act = mInt ? mLatch : mComp;
    expLvl = mHigh ? act : !act;
    checks++;
    if (alarmLevel !== expLvl || alarmPullLow !== !expLvl) begin
      fails++;
      $display("FAIL %s: level=%0b pullLow=%0b expected level=%0b pullLow=%0b",
               tag, alarmLevel, alarmPullLow, expLvl, !expLvl);
    end
  endtask

  task automatic doSample(int t, bit rd, string tag);
    @(negedge clk);
    sampleTemp = t[8:0];
    sampleValid = 1'b1;
    regReadPulse = rd;
    modelSample(t, rd);
    @(negedge clk);
    sampleValid = 1'b0;
    regReadPulse = 1'b0;
    check(tag);
  endtask

  task automatic doRead(string tag);
    @(negedge clk);
    regReadPulse = 1'b1;
    if (mInt) mLatch = 0;
    @(negedge clk);
    regReadPulse = 1'b0;
    check(tag);
  endtask

  task automatic setMode(bit m, string tag);
    @(negedge clk);
    cfgIntMode = m;
    if (m != mInt) begin
      mComp = 0; mLatch = 0; mArm = 0; mRun = 0; mLast = 0;
    end
    mInt = m;
    @(negedge clk);
    check(tag);
  endtask

  task automatic setShut(bit s, string tag);
    @(negedge clk);
    cfgShutdown = s;
    if (s && !mShut && mInt) mLatch = 0;
    mShut = s;
    @(negedge clk);
    check(tag);
  endtask

  task automatic setCfg(int tr, int hy, int depth, bit high);
    @(negedge clk);
    tripPoint = tr[8:0];
    hystPoint = hy[8:0];
    cfgQueueDepth = depth[1:0];
    cfgActiveHigh = high;
    mTrip = tr; mHyst = hy; mDepth = depth; mHigh = high;
  endtask

  task automatic mixedRun(int n, bit withReads, string tag);
    for (int i = 0; i < n; i++) begin
      int pick;
      int t;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pick = int'(lfsr[2:0]);
      if (pick < 3)      t = mTrip + 1 + int'(lfsr[6:3]);
      else if (pick < 6) t = mHyst - 1 - int'(lfsr[6:3]);
      else               t = mHyst;
      doSample(t, withReads && lfsr[9] && lfsr[11], tag);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run still busy (actual hung, expected finished)");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset inactive");
    if (alarmLevel !== 1'b1) begin
      fails++;
      $display("FAIL R1: level=%0b expected=1", alarmLevel);
    end
    checks++;

    // R2: full signed sweep around thresholds straddling zero
    setCfg(10, -10, 0, 0);
    for (int t = -256; t <= 255; t++) doSample(t, 0, "R2 sweep straddle");
    // R2/R4: sweep with default thresholds, exact edges
    setCfg(160, 150, 0, 1);
    for (int t = -256; t <= 255; t++) doSample(t, 0, "R2 sweep default");
    doSample(160, 0, "R2 equal trip not hot");
    doSample(161, 0, "R4 above trip active");
    doSample(150, 0, "R4 equal release holds");
    doSample(155, 0, "R4 neutral holds");
    doSample(149, 0, "R4 below release inactive");

    // R3: every queue depth with mixed classes, thermostat mode
    for (int d = 0; d < 4; d++) begin
      setCfg(40, 20, d, d[0]);
      mixedRun(300, 0, "R3 thermostat depth");
    end
    // R3: depth code 11 needs six
    setCfg(40, 20, 3, 0);
    for (int k = 0; k < 6; k++) doSample(-30, 0, "R3 settle cold");
    for (int k = 0; k < 5; k++) doSample(50, 0, "R3 five hot not enough");
    doSample(30, 0, "R3 neutral restarts");
    for (int k = 0; k < 6; k++) doSample(50, 0, "R3 six hot qualify");

    // R5/R6: interrupt mode, mixed sequences with reads
    setMode(1, "R10 mode change to interrupt");
    for (int d = 0; d < 4; d++) begin
      setCfg(40, 20, d, d[1]);
      mixedRun(300, 1, "R5 R6 interrupt depth");
    end
    setMode(0, "R10 back to thermostat");
    setMode(1, "R10 interrupt fresh");
    setCfg(40, 20, 0, 0);
    doSample(50, 0, "R5 hot fires");
    doSample(30, 0, "R5 neutral keeps latch");
    doSample(30, 0, "R5 still latched");
    doRead("R5 read clears");
    doSample(55, 0, "R6 hot again no refire");
    doSample(10, 0, "R6 cold crossing fires");
    doRead("R6 read clears cold event");
    doSample(5, 0, "R6 cold again no refire");
    doSample(50, 1, "R5 event beats read");
    doRead("R5 read after tie");

    // R7/R8: shutdown
    doSample(10, 0, "R8 cold event");
    setShut(1, "R8 shutdown drops interrupt");
    doSample(60, 0, "R7 ignored in shutdown");
    setShut(0, "R7 resume");
    setMode(0, "R10 to thermostat");
    doSample(60, 0, "R7 thermostat active");
    setShut(1, "R7 thermostat keeps state");
    doSample(-50, 0, "R7 cold ignored");
    doSample(-50, 0, "R7 cold ignored again");
    setShut(0, "R7 resume thermostat");
    doSample(-50, 0, "R7 cold after resume");

    // R9: polarity flip with active alarm
    doSample(60, 0, "R9 active");
    setCfg(40, 20, 0, 1);
    @(negedge clk);
    check("R9 active high level");
    setCfg(40, 20, 0, 0);
    @(negedge clk);
    check("R9 active low level");

    // R10: run counter flushed by mode change
    setCfg(40, 20, 1, 0);
    doSample(-50, 0, "R10 prime cold");
    doSample(-50, 0, "R10 qualify cold");
    doSample(60, 0, "R10 one hot");
    setMode(1, "R10 flush");
    doSample(60, 0, "R10 run restarted");
    doSample(60, 0, "R10 second hot fires");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule